// File: doc/BRIEF.md
# Physical Memory Protection Checker

This block decides, for every instruction fetch, load or store that a hart issues, whether the physical address may be touched. It holds a parameterised number of protection regions (16 by default). Each region has an 8-bit configuration and a word address register. Software-side logic fills these through a single write port. A request presents the byte address, the kind of access, the current privilege level and the two status fields that let machine mode borrow the user level for its data accesses. One clock edge later the block returns either a grant or an access fault.

A region describes its address range in one of three ways. It can be a range ending below its own address, with the previous entry as the lower bound. It can be one aligned 4-byte word. It can be an aligned block whose size is a power of two, encoded by the number of trailing ones in the address register. Regions of different kinds and sizes can sit side by side. When several regions match, the one with the smallest index decides. A lock bit makes a region bind machine mode as well, and it freezes the region's settings until reset.

Top module: `pmp_checker`

## Requirements
- R1: After reset every region is off. A user-level access then faults and a machine-level access is granted.
- R2: A response is given on the cycle after each request. `rsp_valid` is high on the cycle after `req_valid` and low otherwise.
- R3: Configuration byte layout: bit 0 allows loads, bit 1 allows stores, bit 2 allows fetches, bits 4:3 select the match kind (0 off, 1 range, 2 single word, 3 power-of-two block), and bit 7 locks the region. Each permission is checked on its own, with fetch, load and store encoded as 0, 1 and 2 on `req_kind`.
- R4: A range region n matches when the address register of entry n-1 (or 0 for entry 0) is no greater than the access word address, and the access word address is below the region's own address register. Address registers hold byte address bits [PA_W-1:2].
- R5: A single-word region matches only the 4-byte word whose address equals its address register.
- R6: A power-of-two region whose address register ends in k ones covers 2^(k+3) bytes, aligned to that size. The base is the register with those ones cleared.
- R7: When several regions match an access, the lowest-numbered one decides the outcome.
- R8: An access checked at user level that matches no region faults. A machine-level access that matches no region is granted.
- R9: Privilege code 3 is machine and any other code is checked as user level. A machine-level load or store with `req_mprv` set and `req_mpp` equal to 0 is checked as user level. Machine-level fetches ignore these two fields.
- R10: A locked region's permissions also apply to machine-level accesses, including fetches.
- R11: Writes to the configuration byte or the address register of a locked region are ignored until reset.
- R12: A locked range region also ignores writes to the address register of the entry just below it.
- R13: Each response carries exactly one of grant and fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr_en | input | 1 | Write strobe for the region registers |
| cfg_wr_addr_sel | input | 1 | 0 writes the configuration byte, 1 writes the address register |
| cfg_wr_idx | input | IDX_W | Region index to write |
| cfg_wr_data | input | XLEN | Write data; bits [7:0] for configuration, [PA_W-3:0] for address |
| req_valid | input | 1 | Access request strobe |
| req_addr | input | PA_W | Physical byte address of the access |
| req_kind | input | 2 | 0 fetch, 1 load, 2 store |
| req_priv | input | 2 | Current privilege, 3 machine, 0 user |
| req_mprv | input | 1 | Machine data accesses use the previous privilege |
| req_mpp | input | 2 | Previous privilege field |
| rsp_valid | output | 1 | Response strobe, one cycle after a request |
| rsp_grant | output | 1 | Access allowed |
| rsp_fault | output | 1 | Access fault |

## Verification
Each verdict is registered once, so it is due on the clock edge that follows the request. A region write takes effect at its own edge, and a request driven on the next cycle already sees it. The driver sets inputs on falling edges and queues the expected verdict at the same moment. The monitor samples on the next falling edge and takes one item from the queue for every cycle in which `rsp_valid` is high. A response with no queued item, or an item left in the queue at the end, counts as a failure. Requests are also issued back to back to confirm that the one-cycle spacing holds under load.

// File: rtl/pmp_pkg.sv
// Shared encodings for the protection checker.
// Assumes: configuration byte layout is fixed by the requirements.
package pmp_pkg;
    typedef struct packed {
        logic       lock;
        logic [1:0] rsvd;
        logic [1:0] mode;
        logic       x;
        logic       w;
        logic       r;
    } region_cfg_t;

    localparam logic [1:0] MODE_OFF   = 2'd0;
    localparam logic [1:0] MODE_TOR   = 2'd1;
    localparam logic [1:0] MODE_NA4   = 2'd2;
    localparam logic [1:0] MODE_NAPOT = 2'd3;

    localparam logic [1:0] KIND_FETCH = 2'd0;
    localparam logic [1:0] KIND_LOAD  = 2'd1;
    localparam logic [1:0] KIND_STORE = 2'd2;

    localparam logic [1:0] PRIV_USER = 2'd0;
    localparam logic [1:0] PRIV_MACH = 2'd3;
endpackage

// File: rtl/pmp_region_file.sv
// Region register file: one configuration byte and one word address per region.
// Enforces lock bits against writes. Assumes XLEN >= AW.
module pmp_region_file
    import pmp_pkg::*;
#(
    parameter int N     = 16,
    parameter int AW    = 30,
    parameter int XLEN  = 32,
    localparam int IW   = (N > 1) ? $clog2(N) : 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic                  wr_addr_sel,
    input  logic [IW-1:0]         wr_idx,
    input  logic [XLEN-1:0]       wr_data,
    output region_cfg_t [N-1:0]   cfg_o,
    output logic [N-1:0][AW-1:0]  addr_o
);
    region_cfg_t [N-1:0]  cfg_q;
    logic [N-1:0][AW-1:0] addr_q;

    for (genvar g = 0; g < N; g++) begin : g_reg
        logic hit_idx;
        logic above_tor_lock;
        assign hit_idx = wr_en && (wr_idx == IW'(g));

        if (g < N - 1) begin : g_up
            assign above_tor_lock = cfg_q[g+1].lock && (cfg_q[g+1].mode == MODE_TOR);
        end else begin : g_top
            assign above_tor_lock = 1'b0;
        end

        // Configuration byte update, frozen once locked.
        always_ff @(posedge clk) begin
            if (!rst_n)
                cfg_q[g] <= '0;
            else if (hit_idx && !wr_addr_sel && !cfg_q[g].lock)
                cfg_q[g] <= region_cfg_t'({wr_data[7], 2'b00, wr_data[4:0]});
        end

        // Address update, frozen by own lock or a locked range entry above.
        always_ff @(posedge clk) begin
            if (!rst_n)
                addr_q[g] <= '0;
            else if (hit_idx && wr_addr_sel && !cfg_q[g].lock && !above_tor_lock)
                addr_q[g] <= wr_data[AW-1:0];
        end

        p_lock_holds_cfg_r11: assert property (@(posedge clk) disable iff (!rst_n)
            cfg_q[g].lock |=> $stable(cfg_q[g]));
        p_lock_holds_addr_r11: assert property (@(posedge clk) disable iff (!rst_n)
            cfg_q[g].lock |=> $stable(addr_q[g]));
        p_tor_guard_below_r12: assert property (@(posedge clk) disable iff (!rst_n)
            above_tor_lock |=> $stable(addr_q[g]));
    end

    assign cfg_o  = cfg_q;
    assign addr_o = addr_q;
endmodule

// File: rtl/pmp_match.sv
// Per-region address comparison for the three match kinds.
// Assumes word_addr is the byte address without its two low bits.
module pmp_match
    import pmp_pkg::*;
#(
    parameter int N  = 16,
    parameter int AW = 30
) (
    input  logic [AW-1:0]         word_addr,
    input  region_cfg_t [N-1:0]   cfg_i,
    input  logic [N-1:0][AW-1:0]  addr_i,
    output logic [N-1:0]          hit
);
    for (genvar g = 0; g < N; g++) begin : g_cmp
        logic [AW-1:0] lower;
        logic [AW-1:0] block_mask;

        if (g == 0) begin : g_first
            assign lower = '0;
        end else begin : g_rest
            assign lower = addr_i[g-1];
        end

        // Trailing ones plus the next zero form the in-block offset bits.
        assign block_mask = addr_i[g] ^ (addr_i[g] + AW'(1));

        // Select the comparison for this region's match kind.
        always_comb begin
            unique case (cfg_i[g].mode)
                MODE_TOR:   hit[g] = (word_addr >= lower) && (word_addr < addr_i[g]);
                MODE_NA4:   hit[g] = (word_addr == addr_i[g]);
                MODE_NAPOT: hit[g] = ((word_addr ^ addr_i[g]) & ~block_mask) == '0;
                default:    hit[g] = 1'b0;
            endcase
        end
    end
endmodule

// File: rtl/pmp_decide.sv
// Picks the lowest-numbered matching region and turns its permissions
// into a fault verdict. Purely combinational.
module pmp_decide
    import pmp_pkg::*;
#(
    parameter int N = 16
) (
    input  logic [N-1:0]        hit,
    input  region_cfg_t [N-1:0] cfg_i,
    input  logic [1:0]          kind,
    input  logic                eff_user,
    output logic                fault
);
    region_cfg_t sel;
    logic        found;
    logic        perm;

    // Priority scan: lower indices overwrite higher ones.
    always_comb begin
        sel   = '0;
        found = 1'b0;
        for (int i = N - 1; i >= 0; i--) begin
            if (hit[i]) begin
                sel   = cfg_i[i];
                found = 1'b1;
            end
        end
    end

    // Permission bit for this access kind, then the verdict.
    always_comb begin
        unique case (kind)
            KIND_FETCH: perm = sel.x;
            KIND_LOAD:  perm = sel.r;
            default:    perm = sel.w;
        endcase
        if (!found)
            fault = eff_user;
        else if (eff_user || sel.lock)
            fault = !perm;
        else
            fault = 1'b0;
    end
endmodule

// File: rtl/pmp_checker.sv
// Top of the protection checker: region registers, matchers, priority
// decision and a one-cycle registered verdict.
// Assumes one request per cycle at most and PA_W - 2 <= XLEN.
module pmp_checker
    import pmp_pkg::*;
#(
    parameter int NUM_REGIONS = 16,
    parameter int PA_W        = 32,
    parameter int XLEN        = 32,
    localparam int IDX_W      = (NUM_REGIONS > 1) ? $clog2(NUM_REGIONS) : 1,
    localparam int AW         = PA_W - 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr_en,
    input  logic              cfg_wr_addr_sel,
    input  logic [IDX_W-1:0]  cfg_wr_idx,
    input  logic [XLEN-1:0]   cfg_wr_data,
    input  logic              req_valid,
    input  logic [PA_W-1:0]   req_addr,
    input  logic [1:0]        req_kind,
    input  logic [1:0]        req_priv,
    input  logic              req_mprv,
    input  logic [1:0]        req_mpp,
    output logic              rsp_valid,
    output logic              rsp_grant,
    output logic              rsp_fault
);
    region_cfg_t [NUM_REGIONS-1:0]  cfg;
    logic [NUM_REGIONS-1:0][AW-1:0] addr;
    logic [NUM_REGIONS-1:0]         hit;
    logic                           eff_user;
    logic                           fault_c;
    logic                           valid_q;
    logic                           fault_q;

    pmp_region_file #(.N(NUM_REGIONS), .AW(AW), .XLEN(XLEN)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (cfg_wr_en),
        .wr_addr_sel (cfg_wr_addr_sel),
        .wr_idx      (cfg_wr_idx),
        .wr_data     (cfg_wr_data),
        .cfg_o       (cfg),
        .addr_o      (addr)
    );

    pmp_match #(.N(NUM_REGIONS), .AW(AW)) u_match (
        .word_addr (req_addr[PA_W-1:2]),
        .cfg_i     (cfg),
        .addr_i    (addr),
        .hit       (hit)
    );

    // Effective level: borrowed user level for machine data accesses.
    always_comb begin
        eff_user = (req_priv != PRIV_MACH) ||
                   ((req_kind != KIND_FETCH) && req_mprv && (req_mpp == PRIV_USER));
    end

    pmp_decide #(.N(NUM_REGIONS)) u_decide (
        .hit      (hit),
        .cfg_i    (cfg),
        .kind     (req_kind),
        .eff_user (eff_user),
        .fault    (fault_c)
    );

    // Register the verdict one cycle after the request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
            fault_q <= 1'b0;
        end else begin
            valid_q <= req_valid;
            fault_q <= req_valid && fault_c;
        end
    end

    assign rsp_valid = valid_q;
    assign rsp_fault = fault_q;
    assign rsp_grant = valid_q && !fault_q;

    p_rsp_follows_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);
    p_no_rsp_without_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);
    p_one_verdict_r13: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_grant ^ rsp_fault));
    p_user_nomatch_faults_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && eff_user && (hit == '0)) |=> rsp_fault);
    p_mach_nomatch_grants_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !eff_user && (hit == '0)) |=> rsp_grant);
endmodule

// File: tb/pmp_checker_tb.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver queues expected verdicts, the monitor
// compares them against responses on the following falling edge.
module pmp_checker_tb;
    localparam int N = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr_en = 1'b0;
    logic        cfg_wr_addr_sel = 1'b0;
    logic [3:0]  cfg_wr_idx = '0;
    logic [31:0] cfg_wr_data = '0;
    logic        req_valid = 1'b0;
    logic [31:0] req_addr = '0;
    logic [1:0]  req_kind = '0;
    logic [1:0]  req_priv = '0;
    logic        req_mprv = 1'b0;
    logic [1:0]  req_mpp = '0;
    logic        rsp_valid, rsp_grant, rsp_fault;

    int errors = 0;
    int checks = 0;
    bit    exp_q[$];
    string tag_q[$];

    always #2 clk = ~clk;

    pmp_checker #(.NUM_REGIONS(N)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .cfg_wr_en(cfg_wr_en), .cfg_wr_addr_sel(cfg_wr_addr_sel),
        .cfg_wr_idx(cfg_wr_idx), .cfg_wr_data(cfg_wr_data),
        .req_valid(req_valid), .req_addr(req_addr), .req_kind(req_kind),
        .req_priv(req_priv), .req_mprv(req_mprv), .req_mpp(req_mpp),
        .rsp_valid(rsp_valid), .rsp_grant(rsp_grant), .rsp_fault(rsp_fault)
    );

    localparam logic [1:0] F = 2'd0, L = 2'd1, S = 2'd2;
    localparam logic [1:0] U = 2'd0, M = 2'd3;

    task automatic wr(input bit is_addr, input int idx, input logic [31:0] d);
        @(negedge clk);
        req_valid       = 1'b0;
        cfg_wr_en       = 1'b1;
        cfg_wr_addr_sel = is_addr;
        cfg_wr_idx      = 4'(idx);
        cfg_wr_data     = d;
        @(negedge clk);
        cfg_wr_en       = 1'b0;
    endtask

    // Drive one request and queue its expected fault flag; no idle cycle after.
    task automatic acc(input logic [31:0] a, input logic [1:0] k, input logic [1:0] p,
                       input bit mprv, input logic [1:0] mpp, input bit exp_fault,
                       input string tag);
        @(negedge clk);
        req_valid = 1'b1;
        req_addr  = a;
        req_kind  = k;
        req_priv  = p;
        req_mprv  = mprv;
        req_mpp   = mpp;
        exp_q.push_back(exp_fault);
        tag_q.push_back(tag);
    endtask

    task automatic idle();
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    // Monitor: every response pops one expectation.
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && rsp_valid) begin
                checks++;
                if (exp_q.size() == 0) begin
                    errors++;
                    $display("FAIL R2 unexpected response: actual valid=1 expected valid=0");
                end else begin
                    automatic bit    e = exp_q.pop_front();
                    automatic string t = tag_q.pop_front();
                    if (rsp_fault !== e || rsp_grant !== !e) begin
                        errors++;
                        $display("FAIL %s: actual fault=%0b grant=%0b expected fault=%0b",
                                 t, rsp_fault, rsp_grant, e);
                    end
                end
            end
        end
    end

    task automatic summary();
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=hung expected=done");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        checks++;
        if (rsp_valid !== 1'b0) begin
            errors++;
            $display("FAIL R1 reset: actual rsp_valid=%0b expected 0", rsp_valid);
        end
        // R1 / R8: empty table
        acc(32'h1000, L, U, 0, M, 1, "R1 user load after reset");
        acc(32'h1000, F, M, 0, M, 0, "R8 machine fetch no match");
        idle();

        // Region set-up (R3 layout)
        wr(1, 0, 32'h400);  wr(0, 0, 32'h0D);   // range 0..0xFFF, R+X
        wr(1, 1, 32'h800);  wr(0, 1, 32'h13);   // word 0x2000, R+W
        wr(1, 2, 32'hC1F);  wr(0, 2, 32'h19);   // 256B at 0x3000, R
        wr(1, 3, 32'hDFF);  wr(0, 3, 32'h1F);   // 4KB at 0x3000, RWX

        acc(32'h0FFC, F, U, 0, M, 0, "R4 range last word");
        acc(32'h1000, F, U, 0, M, 1, "R4 range upper bound");
        acc(32'h0000, L, U, 0, M, 0, "R4 range lower bound 0");
        acc(32'h0000, S, U, 0, M, 1, "R3 missing write perm");
        acc(32'h2000, S, U, 0, M, 0, "R5 single word store");
        acc(32'h2004, S, U, 0, M, 1, "R5 next word");
        acc(32'h2000, F, U, 0, M, 1, "R3 missing exec perm");
        acc(32'h30FC, L, U, 0, M, 0, "R6 block top load");
        acc(32'h30FC, S, U, 0, M, 1, "R7 small block wins");
        acc(32'h3100, S, U, 0, M, 0, "R6 past small block");
        acc(32'h3FFC, F, U, 0, M, 0, "R6 large block end");
        acc(32'h4000, F, U, 0, M, 1, "R6 past large block");
        acc(32'h5000, L, M, 1, U, 1, "R9 borrowed user load");
        acc(32'h5000, L, M, 1, M, 0, "R9 mpp machine");
        acc(32'h5000, F, M, 1, U, 0, "R9 fetch unaffected");
        acc(32'h0000, S, M, 0, U, 0, "R8 machine unlocked region");
        acc(32'h5000, S, 2'd1, 0, M, 1, "R9 non-machine checked");
        idle();

        // Locked single word at 0x6000, read only
        wr(1, 4, 32'h1800); wr(0, 4, 32'h91);
        acc(32'h6000, F, M, 0, M, 1, "R10 machine fetch locked");
        acc(32'h6000, L, M, 0, M, 0, "R10 machine load locked");
        idle();
        wr(0, 4, 32'h17);
        wr(1, 4, 32'h1C00);
        acc(32'h6000, F, M, 0, M, 1, "R11 cfg write ignored");
        acc(32'h6000, L, U, 0, M, 0, "R11 addr write ignored");
        acc(32'h7000, F, U, 0, M, 1, "R11 no region moved");
        idle();

        // Locked range 0x9000..0x9FFF built on entry 6
        wr(1, 6, 32'h2400);
        wr(1, 7, 32'h2800); wr(0, 7, 32'h89);
        acc(32'h9800, L, U, 0, M, 0, "R4 range from previous entry");
        acc(32'h8FFC, L, U, 0, M, 1, "R4 below previous entry");
        acc(32'h9800, S, M, 0, M, 1, "R10 machine store locked range");
        idle();
        wr(1, 6, 32'h2000);
        acc(32'h8FFC, L, U, 0, M, 1, "R12 lower bound kept");
        acc(32'h9000, L, U, 0, M, 0, "R12 lower bound kept");
        idle();

        repeat (3) @(negedge clk);
        checks++;
        if (exp_q.size() != 0) begin
            errors++;
            $display("FAIL R2 missing responses: actual pending=%0d expected 0", exp_q.size());
        end
        summary();
    end
endmodule